// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This execution unit serves a 64-bit register machine where the destination register doubles as an accumulator. On each accepted request it combines the current destination value with a second operand. That operand is either a source register value or a 32-bit immediate that is sign-extended to 64 bits. The unit returns the new destination value. Every operation can run at full 64-bit width or in a 32-bit mode. In 32-bit mode only the low halves of the operands take part, and the result is zero-extended.

Most operations finish one cycle after acceptance. Unsigned division and remainder use a bit-serial restoring divider that needs one cycle per quotient bit. While the divider is working, the unit ignores new requests, and the caller waits for the result strobe before issuing again. Instruction decode, register storage and memory access are handled outside this block.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `result` = 0.
- R2: With `use_imm` = 1 the second operand is `imm` sign-extended to 64 bits and `src` is ignored. With `use_imm` = 0 the second operand is `src`.
- R3: Add (op 0), subtract (op 1, destination minus operand) and multiply (op 2) keep the low bits of the result and wrap silently.
- R4: AND (op 5), OR (op 6) and XOR (op 7) act bitwise on the destination and the operand.
- R5: Left shift (op 8), logical right shift (op 9) and arithmetic right shift (op 10) shift the destination by the operand's low 6 bits in 64-bit mode and by its low 5 bits in 32-bit mode. Arithmetic right shift copies the sign bit of the active width into the vacated positions.
- R6: Negate (op 11) returns the two's complement of the destination and ignores the operand. Move (op 12) returns the operand and ignores the destination.
- R7: With `w32` = 1 an operation uses bits 31:0 of the destination and the operand. The result's bits 63:32 are zero.
- R8: An accepted operation other than divide or remainder raises `out_valid` for exactly one cycle, in the cycle that follows the accepting edge.
- R9: Unsigned divide (op 3) and remainder (op 4) raise `out_valid` for one cycle. This happens after 64 further clock edges in 64-bit mode, or 32 in 32-bit mode, counted from the accepting edge.
- R10: A zero divisor causes no trap. Divide returns 0. Remainder returns the destination in 64-bit mode, or the destination's low half zero-extended in 32-bit mode.
- R11: A request presented at any of the edges after a divide or remainder is accepted, up to and including the edge that produces its result, is ignored. It produces no extra `out_valid` pulse and does not disturb the pending result.
- R12: Op codes 13 to 15 are undefined. They complete in one cycle and return the full destination value unchanged in either width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe, taken when the divider is idle |
| op | input | 4 | Operation code |
| w32 | input | 1 | 1 selects 32-bit mode |
| use_imm | input | 1 | 1 selects the immediate as the second operand |
| dst | input | 64 | Current destination (accumulator) value |
| src | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 64 | New destination value, meaningful while `out_valid` is high |

## Verification
The assertions rely on three assumptions about the inputs. `rst_n` is held low for at least one edge before the first request. Requests may arrive at any time, including while a division is in flight, and the unit must drop those requests itself. The op code is one of the sixteen 4-bit values, with undefined codes treated as pass-through. The stimulus respects the reset assumption by holding reset for several edges. It deliberately keeps `in_valid` high with varied op codes during divider activity, and it issues every code from 0 to 15 in both widths, so the ignore and pass-through paths are exercised instead of avoided.

// File: rtl/acc_alu_pkg.sv
// Shared operation encoding for the accumulator ALU.
// Assumes a 4-bit op field; codes above OP_MOV are undefined pass-through.
package acc_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_MOD  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_LSH  = 4'd8,
        OP_RSH  = 4'd9,
        OP_ARSH = 4'd10,
        OP_NEG  = 4'd11,
        OP_MOV  = 4'd12
    } alu_op_e;

    function automatic logic needs_divider(input logic [3:0] code);
        return (code == OP_DIV) || (code == OP_MOD);
    endfunction
endpackage

// File: rtl/acc_alu_exec.sv
// Single-cycle datapath: all operations except divide and remainder.
// Assumes a and b are already selected; in half-width mode it uses only the low
// halves and zero-extends the result. Undefined codes return a unchanged.
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   op,
    input  logic         w32,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int H  = W / 2;
    localparam int SW = $clog2(W);

    logic [SW-1:0] amt_full;
    logic [SW-2:0] amt_half;
    logic [H-1:0]  a_lo, b_lo, r_half;
    logic [W-1:0]  r_full;

    assign amt_full = b[SW-1:0];
    assign amt_half = b[SW-2:0];
    assign a_lo     = a[H-1:0];
    assign b_lo     = b[H-1:0];

    // Full-width results.
    always_comb begin
        case (op)
            OP_ADD:  r_full = a + b;
            OP_SUB:  r_full = a - b;
            OP_MUL:  r_full = a * b;
            OP_AND:  r_full = a & b;
            OP_OR:   r_full = a | b;
            OP_XOR:  r_full = a ^ b;
            OP_LSH:  r_full = a << amt_full;
            OP_RSH:  r_full = a >> amt_full;
            OP_ARSH: r_full = W'($signed(a) >>> amt_full);
            OP_NEG:  r_full = -a;
            OP_MOV:  r_full = b;
            default: r_full = a;
        endcase
    end

    // Half-width results.
    always_comb begin
        case (op)
            OP_ADD:  r_half = a_lo + b_lo;
            OP_SUB:  r_half = a_lo - b_lo;
            OP_MUL:  r_half = a_lo * b_lo;
            OP_AND:  r_half = a_lo & b_lo;
            OP_OR:   r_half = a_lo | b_lo;
            OP_XOR:  r_half = a_lo ^ b_lo;
            OP_LSH:  r_half = a_lo << amt_half;
            OP_RSH:  r_half = a_lo >> amt_half;
            OP_ARSH: r_half = H'($signed(a_lo) >>> amt_half);
            OP_NEG:  r_half = -a_lo;
            OP_MOV:  r_half = b_lo;
            default: r_half = a_lo;
        endcase
    end

    // Width select; undefined codes keep the whole destination.
    always_comb begin
        if (op > OP_MOV)  y = a;
        else if (w32)     y = {{H{1'b0}}, r_half};
        else              y = r_full;
    end
endmodule

// File: rtl/acc_alu_div.sv
// Bit-serial restoring unsigned divider, one quotient bit per cycle.
// Assumes start is raised only while busy is low. Half-width jobs left-align
// the dividend and run H steps. A zero divisor forces the quotient to 0; the
// remainder then naturally equals the dividend.
module acc_alu_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         w32,
    input  logic         want_rem,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W);

    logic          busy_q, done_q, w32_q, rem_q_sel, zero_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  quo_q, rem_q, dvs_q, res_q;
    logic [W:0]    shifted, diff;
    logic          fits, last;
    logic [W-1:0]  rem_nx, quo_nx;

    // One restoring step: shift in next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
        rem_nx  = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_nx  = {quo_q[W-2:0], fits};
        last    = cnt_q == (w32_q ? CW'(H - 1) : CW'(W - 1));
    end

    // Job load, iteration and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; done_q <= 1'b0; w32_q <= 1'b0; rem_q_sel <= 1'b0;
            zero_q <= 1'b0; cnt_q <= '0; quo_q <= '0; rem_q <= '0;
            dvs_q  <= '0;   res_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (rem_q_sel)   res_q <= w32_q ? {{H{1'b0}}, rem_nx[H-1:0]} : rem_nx;
                    else if (zero_q) res_q <= '0;
                    else             res_q <= w32_q ? {{H{1'b0}}, quo_nx[H-1:0]} : quo_nx;
                end
            end else if (start) begin
                busy_q    <= 1'b1;
                w32_q     <= w32;
                rem_q_sel <= want_rem;
                cnt_q     <= '0;
                rem_q     <= '0;
                quo_q     <= w32 ? {dividend[H-1:0], {H{1'b0}}} : dividend;
                dvs_q     <= w32 ? {{H{1'b0}}, divisor[H-1:0]} : divisor;
                zero_q    <= w32 ? (divisor[H-1:0] == '0) : (divisor == '0);
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign res  = res_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q);
    // R9
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && w32_q) |-> (cnt_q < CW'(H)));
    // R7
    half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && w32_q) |-> (res_q[W-1:H] == '0));
endmodule

// File: rtl/acc_alu.sv
// Top of the accumulator ALU: operand select, single-cycle path and divider.
// Assumes the caller waits for out_valid after a divide; requests arriving
// while the divider is busy are dropped. Results are one-cycle strobes.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 64,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic             w32,
    input  logic             use_imm,
    input  logic [W-1:0]     dst,
    input  logic [W-1:0]     src,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [W-1:0]     result
);
    localparam int H = W / 2;

    logic [W-1:0] opnd_b, exec_y, div_res, res_q;
    logic         div_busy, div_done, vld_q, accept, is_div;

    // Second operand: register or sign-extended immediate.
    assign opnd_b = use_imm ? {{(W-IMM_W){imm[IMM_W-1]}}, imm} : src;
    assign is_div = needs_divider(op);
    assign accept = in_valid && !div_busy;

    acc_alu_exec #(.W(W)) u_exec (
        .op(op), .w32(w32), .a(dst), .b(opnd_b), .y(exec_y)
    );

    acc_alu_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(accept && is_div), .w32(w32),
        .want_rem(op == OP_MOD), .dividend(dst), .divisor(opnd_b),
        .busy(div_busy), .done(div_done), .res(div_res)
    );

    // Register single-cycle results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= accept && !is_div;
            if (accept && !is_div) res_q <= exec_y;
        end
    end

    assign out_valid = vld_q | div_done;
    assign result    = div_done ? div_res : res_q;

    // R8
    single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_div) |=> out_valid);
    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && div_busy) |=> !vld_q);
    // R7
    narrow_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_div && w32 && op <= OP_MOV) |=> (result[W-1:H] == '0));
    // R6
    move_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_MOV && !w32) |=> (result == $past(opnd_b)));
    // R8
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q && div_done));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    localparam logic [3:0] C_ADD = 4'd0, C_SUB = 4'd1, C_MUL = 4'd2, C_DIV = 4'd3,
                           C_MOD = 4'd4, C_AND = 4'd5, C_OR = 4'd6, C_XOR = 4'd7,
                           C_LSH = 4'd8, C_RSH = 4'd9, C_ARSH = 4'd10, C_NEG = 4'd11,
                           C_MOV = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        w32 = 1'b0, use_imm = 1'b0;
    logic [63:0] dst = '0, src = '0;
    logic [31:0] imm = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_vec = 0, n_bad = 0, n_cyc = 0;
    logic        m_vld = 1'b0;
    logic [63:0] m_res = '0, m_pend = '0;
    int          m_cnt = 0;
    string       m_tag = "R1", m_pend_tag = "R9";

    always #10 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .w32(w32),
        .use_imm(use_imm), .dst(dst), .src(src), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [3:0] c, input logic h,
        input logic ui, input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
        logic [63:0] b;
        logic [31:0] a32, b32, r32;
        logic signed [31:0] sa32;
        logic signed [63:0] sa64;
        b = ui ? {{32{im[31]}}, im} : s;
        if (c > C_MOV) return d;
        if (h) begin
            a32 = d[31:0]; b32 = b[31:0]; sa32 = a32;
            case (c)
                C_ADD: r32 = a32 + b32;
                C_SUB: r32 = a32 - b32;
                C_MUL: r32 = a32 * b32;
                C_DIV: r32 = (b32 == 0) ? 32'd0 : a32 / b32;
                C_MOD: r32 = (b32 == 0) ? a32 : a32 % b32;
                C_AND: r32 = a32 & b32;
                C_OR:  r32 = a32 | b32;
                C_XOR: r32 = a32 ^ b32;
                C_LSH: r32 = a32 << b32[4:0];
                C_RSH: r32 = a32 >> b32[4:0];
                C_ARSH: r32 = sa32 >>> b32[4:0];
                C_NEG: r32 = 32'd0 - a32;
                default: r32 = b32;
            endcase
            return {32'd0, r32};
        end
        sa64 = d;
        case (c)
            C_ADD: return d + b;
            C_SUB: return d - b;
            C_MUL: return d * b;
            C_DIV: return (b == 0) ? 64'd0 : d / b;
            C_MOD: return (b == 0) ? d : d % b;
            C_AND: return d & b;
            C_OR:  return d | b;
            C_XOR: return d ^ b;
            C_LSH: return d << b[5:0];
            C_RSH: return d >> b[5:0];
            C_ARSH: return sa64 >>> b[5:0];
            C_NEG: return 64'd0 - d;
            default: return b;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Compare outputs against the model state for the current cycle.
    task automatic compare();
        n_vec++;
        if (out_valid !== m_vld || (m_vld && result !== m_res)) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b result=%h expected out_valid=%0b result=%h",
                     m_tag, out_valid, result, m_vld, m_res);
        end
    endtask

    // One clock: check, drive, advance model, then move to the next falling edge.
    task automatic cycle(input logic v, input logic [3:0] c, input logic h, input logic ui,
        input logic [63:0] d, input logic [63:0] s, input logic [31:0] im, input string tag);
        compare();
        in_valid = v; op = c; w32 = h; use_imm = ui; dst = d; src = s; imm = im;
        if (m_cnt > 0) begin
            m_cnt--;
            m_vld = (m_cnt == 0);
            if (m_cnt == 0) begin m_res = m_pend; m_tag = m_pend_tag; end
        end else if (v) begin
            if (c == C_DIV || c == C_MOD) begin
                m_cnt = h ? 32 : 64; m_vld = 1'b0;
                m_pend = model(c, h, ui, d, s, im); m_pend_tag = tag;
            end else begin
                m_vld = 1'b1; m_res = model(c, h, ui, d, s, im); m_tag = tag;
            end
        end else m_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cycle(1'b0, 4'd0, 1'b0, 1'b0, 64'd0, 64'd0, 32'd0, m_tag);
    endtask

    // Issue one request and run until the result has been compared.
    task automatic issue(input logic [3:0] c, input logic h, input logic ui,
        input logic [63:0] d, input logic [63:0] s, input logic [31:0] im, input string tag);
        cycle(1'b1, c, h, ui, d, s, im, tag);
        while (m_cnt > 0 || m_vld) idle();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected completion", n_cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compare();
        rst_n = 1'b1;

        // R3 arithmetic with wrap
        issue(C_ADD, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'd0, "R3");
        issue(C_SUB, 0, 0, 64'd5, 64'd9, 32'd0, "R3");
        issue(C_MUL, 0, 0, 64'h1_0000_0001, 64'h1_0000_0003, 32'd0, "R3");
        // R2 immediate sign-extension and src ignored
        issue(C_ADD, 0, 1, 64'd100, 64'hDEAD, 32'hFFFF_FFF6, "R2");
        issue(C_MOV, 0, 1, 64'd7, 64'd8, 32'h8000_0000, "R2");
        issue(C_OR, 0, 1, 64'd0, 64'd0, 32'h7FFF_0000, "R2");
        // R4 bitwise
        issue(C_AND, 0, 0, 64'hF0F0_F0F0_1234_5678, 64'h0FF0_FF00_FFFF_0000, 32'd0, "R4");
        issue(C_OR,  0, 0, 64'hA000_0000_0000_0001, 64'h0500_0000_0000_0010, 32'd0, "R4");
        issue(C_XOR, 0, 0, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 32'd0, "R4");
        // R5 shifts, masked amounts
        issue(C_LSH,  0, 0, 64'd1, 64'd63, 32'd0, "R5");
        issue(C_LSH,  0, 0, 64'd3, 64'd64, 32'd0, "R5");
        issue(C_RSH,  0, 1, 64'h8000_0000_0000_0000, 64'd0, 32'd70, "R5");
        issue(C_ARSH, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R5");
        issue(C_ARSH, 1, 0, 64'h0000_0001_8000_0000, 64'd33, 32'd0, "R5");
        issue(C_RSH,  1, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 32'd0, "R5");
        // R6 negate and move
        issue(C_NEG, 0, 0, 64'd1, 64'h1234, 32'd0, "R6");
        issue(C_NEG, 1, 1, 64'h5_0000_0003, 64'd0, 32'h1111, "R6");
        issue(C_MOV, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hCAFE_F00D_0000_0001, 32'd0, "R6");
        // R7 half width with busy upper halves
        issue(C_ADD, 1, 0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0001, 32'd0, "R7");
        issue(C_MUL, 1, 1, 64'hFFFF_0000_0001_0000, 64'd0, 32'h0001_0000, "R7");
        issue(C_MOV, 1, 1, 64'd0, 64'd0, 32'hFFFF_FFFF, "R7");
        // R8 back-to-back single-cycle requests
        cycle(1, C_ADD, 0, 0, 64'd1, 64'd1, 32'd0, "R8");
        cycle(1, C_SUB, 0, 0, 64'd1, 64'd1, 32'd0, "R8");
        cycle(1, C_XOR, 1, 1, 64'd3, 64'd0, 32'd6, "R8");
        idle(); idle();
        // R9 division
        issue(C_DIV, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 32'd0, "R9");
        issue(C_MOD, 0, 0, 64'd1_000_000_007, 64'd1000, 32'd0, "R9");
        issue(C_DIV, 1, 0, 64'h1234_5678_FFFF_FFFE, 64'hFF_0000_0003, 32'd0, "R9");
        issue(C_MOD, 1, 1, 64'd100, 64'd0, 32'd9, "R9");
        issue(C_DIV, 0, 0, 64'd5, 64'd9, 32'd0, "R9");
        // R10 zero divisor
        issue(C_DIV, 0, 0, 64'd77, 64'd0, 32'd0, "R10");
        issue(C_MOD, 0, 0, 64'hDEAD_BEEF_0000_0001, 64'd0, 32'd0, "R10");
        issue(C_MOD, 1, 0, 64'hDEAD_BEEF_0000_0042, 64'h5_0000_0000, 32'd0, "R10");
        issue(C_DIV, 1, 1, 64'd9, 64'd0, 32'd0, "R10");
        // R11 requests while the divider runs
        cycle(1, C_DIV, 0, 0, 64'd1000, 64'd10, 32'd0, "R11");
        for (int k = 0; k < 70; k++)
            cycle(1, 4'(k % 16), k[0], k[1], 64'(k * 3), 64'd1, 32'd5, "R11");
        while (m_cnt > 0 || m_vld) idle();
        // R12 undefined codes
        issue(4'd13, 0, 0, 64'h0123_4567_89AB_CDEF, 64'd1, 32'd0, "R12");
        issue(4'd14, 1, 1, 64'hFEDC_BA98_7654_3210, 64'd1, 32'd3, "R12");
        issue(4'd15, 1, 0, 64'h8000_0000_8000_0000, 64'd1, 32'd0, "R12");
        // Mixed random traffic, tag follows the operation
        for (int k = 0; k < 400; k++) begin
            logic [3:0] c;
            string t;
            c = 4'($urandom_range(0, 15));
            if (c == C_DIV || c == C_MOD) t = "R9";
            else if (c > C_MOV) t = "R12";
            else if (c >= C_LSH && c <= C_ARSH) t = "R5";
            else t = "R3";
            cycle($urandom_range(0, 3) != 0, c, 1'($urandom), 1'($urandom),
                  {$urandom, $urandom}, ($urandom_range(0, 9) == 0) ? 64'd0 : {$urandom, $urandom},
                  $urandom, t);
        end
        while (m_cnt > 0 || m_vld) idle();
        idle();
        finish_run();
    end
endmodule